// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column addresses for one read or write burst to a double-data-rate mobile SDRAM. A start pulse loads three things: a starting column, a burst-length code and a wrap-order select (linear or interleaved). Two data beats move on every clock, so each output step carries a pair of addresses. The first address of the pair is for the beat on the rising half. The second is for the beat on the falling half. A burst of BL beats therefore takes BL/2 steps.

The block drives a valid flag while a burst runs and a last flag on its final step. A single terminate input ends a burst early. The surrounding controller raises it for a burst-stop command and for a precharge to the same bank. A length code outside the supported set raises a one-cycle error flag and yields no addresses.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is asserted and after its release with no start, `valid`, `last` and `err` are 0.
- R2: `bl_code` values 1, 2, 3 and 4 select bursts of 2, 4, 8 and 16 beats. Codes 0, 5, 6 and 7 are reserved. A start with a reserved code sets `err` for exactly the next cycle, keeps `valid` low and ends any burst in progress.
- R3: The first step appears on the outputs in the cycle after the clock edge that samples `start`. One step follows per clock, for BL/2 steps in total.
- R4: At step k, `col_even` holds the address of beat 2k and `col_odd` the address of beat 2k+1.
- R5: With `interleave`=0, beat i has low log2(BL) bits equal to (start low bits + i) mod BL.
- R6: With `interleave`=1, beat i has low log2(BL) bits equal to (start low bits) XOR i.
- R7: Column bits above the low log2(BL) bits equal those of the starting column for every beat.
- R8: For a 2-beat burst, bit 0 of the starting column is treated as 0, so the pair is (even, odd) in both orders.
- R9: `last` is high only on the final step of a burst. `valid` drops in the next cycle unless a new start is sampled.
- R10: `stop` sampled high with no `start` ends the burst, and `valid` is low from the next cycle. With no burst running, `stop` has no effect on the outputs.
- R11: A start sampled during a burst restarts with the new parameters from step 0. When `start` and `stop` are high together, the start takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load a new burst |
| start_col | input | 10 | Starting column address |
| bl_code | input | 3 | Burst length code (1:2, 2:4, 3:8, 4:16 beats) |
| interleave | input | 1 | 0 linear wrap, 1 interleaved order |
| stop | input | 1 | Terminate the running burst (burst stop or same-bank precharge) |
| col_even | output | 10 | Column of the first beat of the current pair |
| col_odd | output | 10 | Column of the second beat of the current pair |
| valid | output | 1 | A pair is being presented |
| last | output | 1 | Current pair is the final one of the burst |
| err | output | 1 | Reserved length code was loaded (one cycle) |

## Verification
Every result is due one clock after the edge that samples its command. A start shows step 0, a reserved code shows `err`, and a stop shows `valid` low at the next edge. After that, one pair follows per edge until the final step. The bench drives inputs at the falling edge. At the rising edge it advances a behavioural model that uses division and modulo arithmetic. At the next falling edge it compares every output with the model, so each check lands in exactly the cycle the requirement names. Runs cover both orders at all four lengths, odd and high starting columns, reserved codes in idle and mid-burst, stops, and restarts.

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W  = 10,
  parameter int MAX_BL = 16,
  parameter int CODE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [CODE_W-1:0] bl_code,
  input  logic             interleave,
  input  logic             stop,
  output logic [COL_W-1:0] col_even,
  output logic [COL_W-1:0] col_odd,
  output logic             valid,
  output logic             last,
  output logic             err
);
  localparam int LG_MAX = $clog2(MAX_BL);
  localparam int STEP_W = $clog2(MAX_BL / 2);

  logic              busy, ilv_q, err_q;
  logic [STEP_W-1:0] step;
  logic [CODE_W-1:0] lg;
  logic [COL_W-1:0]  base, mask, idx_e, idx_o, low_e, low_o;
  logic [STEP_W:0]   nsteps;
  logic              legal, final_step;

  assign legal      = (bl_code != '0) && (int'(bl_code) <= LG_MAX);
  assign mask       = ~({COL_W{1'b1}} << lg);
  assign nsteps     = (STEP_W+1)'(1) << (lg - CODE_W'(1));
  assign final_step = ({1'b0, step} == nsteps - (STEP_W+1)'(1));

  assign idx_e = COL_W'({step, 1'b0});
  assign idx_o = COL_W'({step, 1'b1});
  assign low_e = ilv_q ? (base ^ idx_e) : (base + idx_e);
  assign low_o = ilv_q ? (base ^ idx_o) : (base + idx_o);

  assign col_even = (base & ~mask) | (low_e & mask);
  assign col_odd  = (base & ~mask) | (low_o & mask);
  assign valid    = busy;
  assign last     = busy && final_step;
  assign err      = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      step  <= '0;
      lg    <= '0;
      ilv_q <= 1'b0;
      base  <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= start && !legal;
      if (start) begin
        busy <= legal;
        step <= '0;
        if (legal) begin
          lg    <= bl_code;
          ilv_q <= interleave;
          base  <= (bl_code == CODE_W'(1)) ? {start_col[COL_W-1:1], 1'b0} : start_col;
        end
      end else if (stop) begin
        busy <= 1'b0;
      end else if (busy) begin
        if (final_step) busy <= 1'b0;
        else            step <= step + STEP_W'(1);
      end
    end
  end
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W  = 10,
  parameter int MAX_BL = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             stop,
  input logic [COL_W-1:0] col_even,
  input logic [COL_W-1:0] col_odd,
  input logic             valid,
  input logic             last,
  input logic             err
);
  localparam int LG = $clog2(MAX_BL);

  p_last_in_burst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> valid);
  p_end_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    last && !start |=> !valid);
  p_err_no_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !valid);
  p_err_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err && !start |=> !err);
  p_stop_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop && !start |=> !valid);
  p_keeps_going_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !last && !stop && !start |=> valid);
  p_upper_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> col_even[COL_W-1:LG] == col_odd[COL_W-1:LG]);
  p_pair_distinct_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> col_even != col_odd);
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W), .MAX_BL(MAX_BL)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
  .col_even(col_even), .col_odd(col_odd), .valid(valid), .last(last), .err(err)
);

// File: tb/sim_burst_col_gen.sv
`timescale 1ns/1ps
module sim_burst_col_gen;
  logic clk = 0, rst_n = 0, start = 0, interleave = 0, stop = 0;
  logic [9:0] start_col = 0;
  logic [2:0] bl_code = 0;
  logic [9:0] col_even, col_odd;
  logic valid, last, err;
  int checks = 0, errors = 0;

  int m_active = 0, m_k = 0, m_len = 2, m_base = 0, m_err = 0;
  bit m_ilv = 0;

  always #10 clk = ~clk;

  burst_col_gen u0 (.clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .bl_code(bl_code), .interleave(interleave), .stop(stop), .col_even(col_even),
    .col_odd(col_odd), .valid(valid), .last(last), .err(err));

  function automatic int exp_beat(int b, int len, bit il, int i);
    int lo = b % len;
    int hi = b - lo;
    return il ? hi + (lo ^ i) : hi + ((lo + i) % len);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(string tag, bit s, int c, int code, bit il, bit st);
    int last_k;
    start = s; start_col = 10'(c); bl_code = 3'(code); interleave = il; stop = st;
    @(posedge clk);
    m_err = (s && !(code >= 1 && code <= 4)) ? 1 : 0;
    if (s) begin
      if (code >= 1 && code <= 4) begin
        m_active = 1; m_k = 0; m_len = 1 << code; m_ilv = il;
        m_base = (m_len == 2) ? (c / 2) * 2 : c;
      end else m_active = 0;
    end else if (st) m_active = 0;
    else if (m_active != 0) begin
      if (m_k == m_len / 2 - 1) m_active = 0;
      else m_k++;
    end
    @(negedge clk);
    start = 0; stop = 0;
    last_k = m_len / 2 - 1;
    chk(tag, "valid", int'(valid), m_active);
    chk(tag, "last", int'(last), (m_active != 0 && m_k == last_k) ? 1 : 0);
    chk(tag, "err", int'(err), m_err);
    if (m_active != 0) begin
      chk(tag, "col_even", int'(col_even), exp_beat(m_base, m_len, m_ilv, 2 * m_k));
      chk(tag, "col_odd", int'(col_odd), exp_beat(m_base, m_len, m_ilv, 2 * m_k + 1));
    end
  endtask

  task automatic burst(string tag, int c, int code, bit il);
    cyc(tag, 1, c, code, il, 0);
    for (int n = 0; n < 9; n++) cyc(tag, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(20 * 50000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "valid", int'(valid), 0);
    chk("R1", "last", int'(last), 0);
    chk("R1", "err", int'(err), 0);
    rst_n = 1;
    cyc("R1", 0, 0, 0, 0, 0);
    // R5 / R6 / R3 / R4: 8-beat bursts from an odd column
    burst("R5", 'h15, 3, 0);
    burst("R6", 'h15, 3, 1);
    // R7: 16-beat bursts with high columns
    burst("R7", 'h3FB, 4, 0);
    burst("R7", 'h2A3, 4, 1);
    // R4: 4-beat
    burst("R4", 3, 2, 0);
    burst("R4", 6, 2, 1);
    // R8: 2-beat with odd start
    burst("R8", 'h101, 1, 0);
    burst("R8", 'h0FF, 1, 1);
    // R2: reserved codes idle and mid-burst
    for (int code = 5; code < 8; code++) cyc("R2", 1, 'h20, code, 0, 0);
    cyc("R2", 1, 'h20, 0, 1, 0);
    cyc("R2", 0, 0, 0, 0, 0);
    cyc("R2", 1, 'h40, 4, 0, 0);
    cyc("R2", 0, 0, 0, 0, 0);
    cyc("R2", 1, 'h40, 7, 0, 0);
    cyc("R2", 0, 0, 0, 0, 0);
    // R10: stop mid-burst, then idle stop
    cyc("R10", 1, 'h1C7, 4, 1, 0);
    cyc("R10", 0, 0, 0, 0, 0);
    cyc("R10", 0, 0, 0, 0, 1);
    cyc("R10", 0, 0, 0, 0, 0);
    cyc("R10", 0, 0, 0, 0, 1);
    cyc("R10", 0, 0, 0, 0, 0);
    // R11: restart mid-burst, and start together with stop
    cyc("R11", 1, 'h08, 4, 0, 0);
    cyc("R11", 0, 0, 0, 0, 0);
    cyc("R11", 1, 'h35, 3, 1, 0);
    cyc("R11", 0, 0, 0, 0, 0);
    cyc("R11", 1, 'h2E, 2, 0, 1);
    for (int n = 0; n < 4; n++) cyc("R11", 0, 0, 0, 0, 0);
    // R9: back-to-back start right on the last step
    cyc("R9", 1, 'h11, 2, 0, 0);
    cyc("R9", 0, 0, 0, 0, 0);
    burst("R9", 'h12, 2, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule